// File: doc/BRIEF.md
# Five-Level Stacked-Carrier PWM Modulator

This block turns a digital sinusoidal reference into a five-level phase command for a hybrid inverter leg. That leg is a two-level half-leg in series with a capacitor-fed H-bridge. The block keeps one triangular carrier counter that all phases share. From it, four carriers are formed by stacking the same triangle at four offsets, one per band between adjacent output levels. Each phase latches its reference once per carrier period, at the carrier top. It then counts how many of the four stacked carriers the latched reference lies above. That count, shifted down by two, is the signed level command, from -2 to +2.

The level is then split between the two parts of the leg. The half-leg follows only the polarity of the latched reference, so it switches at fundamental rate in square-wave fashion. The H-bridge command is whatever remains, and it always stays within -1..+1. A switch-state decoder downstream consumes both. A carrier tick input sets the carrier speed. A rate input sets the step size, and so the carrier period. The sine generator sits outside the block.

Top module: `lscpwm_mod`

## Requirements
- R1: Synchronous active-low reset gives lvl_out 0, leg_hi 0, hb_out +1 and samp_stb 0 for every phase. The carrier counter is at zero and rising, every latched reference is 0, and the carrier step is 1.
- R2: One triangular counter C runs between 0 and T = 2^(REF_W-2) and is shared by all phases. It changes only on a cycle with car_tick high. On such a tick it steps down when C = T, steps up when C = 0, and otherwise continues in its current direction. Without a tick it holds.
- R3: A phase's reference is latched only on a tick taken while C = T. samp_stb is high in the cycle after each such tick and low otherwise. Changes to ref_in at any other time have no effect on the outputs.
- R4: With U = latched reference + 2^(REF_W-1), lvl_out for a phase equals the number of k in 0..3 with U > k*T + C, minus 2. It is a 3-bit two's complement value at bits [3p+2:3p].
- R5: leg_hi[p] is 1 exactly when the latched reference of phase p is greater than zero. It changes only in the cycle after samp_stb is high.
- R6: hb_out for a phase equals lvl_out minus +1 when leg_hi is 1, or minus -1 when leg_hi is 0. It is a 2-bit two's complement value at bits [2p+1:2p] and always lies in -1..+1.
- R7: All outputs are registered. lvl_out, leg_hi and hb_out reflect the counter and latched references as they stood one clock earlier.
- R8: Phases are computed independently from their own references against the one shared carrier.
- R9: The carrier step is 2^min(car_rate, REF_W-2). A new car_rate value is taken only on a tick leaving C = 0 and is ignored at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| car_tick | input | 1 | Advances the carrier by one step |
| car_rate | input | RATE_W | log2 of the carrier step; sets the carrier period |
| ref_in | input | NPHASE*REF_W | Signed reference per phase, phase p at [REF_W*p +: REF_W] |
| samp_stb | output | 1 | Pulse after each reference latch at the carrier top |
| leg_hi | output | NPHASE | Half-leg polarity per phase, 1 = positive |
| lvl_out | output | NPHASE*3 | Signed five-level command per phase |
| hb_out | output | NPHASE*2 | Signed H-bridge command per phase |

## Verification
A counter that drifts off its step grid, or misses its top or bottom, shows up first as a wrong lvl_out. That happens within one clock of the bad count, because every carrier comparison depends on the count. It also shows up as a missing or misplaced samp_stb at the next expected peak. A latch that takes a reference off the peak, or a rate change applied mid-period, corrupts the level pattern from the next cycle onward. A polarity or split error surfaces at leg_hi or hb_out one cycle after the latch. The bench therefore predicts all four outputs on every cycle. It does so under held, extreme, fast-changing and randomly ticked references and under rate changes.

// File: rtl/lscpwm_pkg.sv
// Shared types and helper functions for the stacked-carrier modulator.
// Assumes five output levels, hence four carrier bands.
package lscpwm_pkg;

    localparam int NCAR  = 4;
    localparam int LVL_W = 3;
    localparam int HB_W  = 2;

    typedef logic signed [LVL_W-1:0] lvl_t;
    typedef logic signed [HB_W-1:0]  hb_t;

    // Map the number of carriers exceeded (0..4) to a level -2..+2.
    function automatic lvl_t lvl_of_count(input logic [2:0] n);
        logic signed [3:0] t;
        t = $signed({1'b0, n}) - 4'sd2;
        return t[LVL_W-1:0];
    endfunction

    // Remove the half-leg contribution (+1 or -1) from the total level.
    function automatic hb_t hb_of_split(input lvl_t l, input logic hi);
        logic signed [3:0] lx;
        logic signed [3:0] t;
        lx = {l[LVL_W-1], l};
        t  = hi ? (lx - 4'sd1) : (lx + 4'sd1);
        return t[HB_W-1:0];
    endfunction

endpackage

// File: rtl/lscpwm_carrier.sv
// Shared triangular carrier counter.
// Counts 0..TOP..0 by a power-of-two step and advances only on tick.
// Assumes TOP = 2^CW, so every legal step divides TOP exactly.
// A new step size is taken only when leaving zero, which keeps each period on one grid.
module lscpwm_carrier #(
    parameter int CW     = 10,
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate_sel,
    output logic [CW:0]       cnt_o,
    output logic              peak_o
);
    localparam logic [CW:0]       TOP     = (CW+1)'(1) << CW;
    localparam logic [RATE_W-1:0] RATE_MX = RATE_W'(CW);

    logic [CW:0]       cnt;
    logic              going_up;
    logic [RATE_W-1:0] sh_q;
    logic [RATE_W-1:0] sh_new;
    logic [CW:0]       step_cur;
    logic [CW:0]       step_new;

    // Clamp the requested rate so the step never exceeds the carrier height.
    always_comb begin
        sh_new   = (rate_sel > RATE_MX) ? RATE_MX : rate_sel;
        step_cur = (CW+1)'(1) << sh_q;
        step_new = (CW+1)'(1) << sh_new;
    end

    // Triangle counter with direction flag and period-aligned step latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            going_up <= 1'b1;
            sh_q     <= '0;
        end else if (tick) begin
            if (cnt == TOP) begin
                cnt      <= cnt - step_cur;
                going_up <= 1'b0;
            end else if (cnt == '0) begin
                sh_q     <= sh_new;
                cnt      <= step_new;
                going_up <= 1'b1;
            end else if (going_up) begin
                cnt <= cnt + step_cur;
            end else begin
                cnt <= cnt - step_cur;
            end
        end
    end

    assign cnt_o  = cnt;
    assign peak_o = tick && (cnt == TOP);

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
    p_cnt_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !$stable(cnt));
    p_rate_only_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && cnt == '0) |=> $stable(sh_q));

endmodule

// File: rtl/lscpwm_phase.sv
// One phase: reference latch, four stacked-carrier comparators, level split.
// Assumes the carrier count is 0..2^CW and the reference spans 4 bands of 2^CW.
// All outputs are registered, one clock after the count and latched reference.
module lscpwm_phase
    import lscpwm_pkg::*;
#(
    parameter int REF_W = 12,
    parameter int CW    = REF_W - 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic                    load_i,
    input  logic [CW:0]             cnt_i,
    output lvl_t                    lvl_o,
    output logic                    leg_hi_o,
    output hb_t                     hb_o
);
    logic signed [REF_W-1:0] ref_q;
    logic [REF_W-1:0]        u_ref;
    logic [NCAR-1:0]         above;
    logic [2:0]              n_above;
    lvl_t                    lvl_now;
    logic                    leg_now;

    // Latch the reference at the carrier top only.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= '0;
        else if (load_i) ref_q <= ref_i;
    end

    // Offset-binary form of the reference: 0 maps to the middle of the range.
    assign u_ref = {~ref_q[REF_W-1], ref_q[REF_W-2:0]};

    // One comparator per stacked carrier band.
    for (genvar k = 0; k < NCAR; k++) begin : g_band
        localparam logic [REF_W:0] OFS = (REF_W+1)'(k) << CW;
        logic [REF_W:0] car_val;
        assign car_val  = OFS + {{(REF_W-CW){1'b0}}, cnt_i};
        assign above[k] = {1'b0, u_ref} > car_val;
        if (k > 0) begin : g_thermo
            p_thermo_r4: assert property (@(posedge clk) disable iff (!rst_n)
                above[k] |-> above[k-1]);
        end
    end

    // Count carriers exceeded and derive level and half-leg polarity.
    always_comb begin
        n_above = '0;
        for (int k = 0; k < NCAR; k++) n_above = n_above + 3'(above[k]);
        lvl_now = lvl_of_count(n_above);
        leg_now = (ref_q > 0);
    end

    // Register the phase outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_o    <= '0;
            leg_hi_o <= 1'b0;
            hb_o     <= 2'sd1;
        end else begin
            lvl_o    <= lvl_now;
            leg_hi_o <= leg_now;
            hb_o     <= hb_of_split(lvl_now, leg_now);
        end
    end

    p_ref_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(ref_q));
    p_lvl_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o >= -3'sd2) && (lvl_o <= 3'sd2));
    p_leg_at_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(leg_hi_o) |-> $past(load_i, 2));
    p_hb_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hb_o != -2'sd2);

endmodule

// File: rtl/lscpwm_mod.sv
// Five-level stacked-carrier modulator, top level.
// One shared carrier drives NPHASE independent phase slices.
// Assumes REF_W >= 4 and car_rate is a log2 step size, clamped to REF_W-2.
module lscpwm_mod
    import lscpwm_pkg::*;
#(
    parameter  int NPHASE = 3,
    parameter  int REF_W  = 12,
    localparam int CW     = REF_W - 2,
    localparam int RATE_W = $clog2(CW + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      car_tick,
    input  logic [RATE_W-1:0]         car_rate,
    input  logic [NPHASE*REF_W-1:0]   ref_in,
    output logic                      samp_stb,
    output logic [NPHASE-1:0]         leg_hi,
    output logic [NPHASE*LVL_W-1:0]   lvl_out,
    output logic [NPHASE*HB_W-1:0]    hb_out
);
    logic [CW:0] cnt;
    logic        peak;

    lscpwm_carrier #(.CW(CW), .RATE_W(RATE_W)) u_car (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (car_tick),
        .rate_sel (car_rate),
        .cnt_o    (cnt),
        .peak_o   (peak)
    );

    // Pulse one cycle after each reference latch.
    always_ff @(posedge clk) begin
        if (!rst_n) samp_stb <= 1'b0;
        else        samp_stb <= peak;
    end

    for (genvar p = 0; p < NPHASE; p++) begin : g_ph
        lvl_t lvl_p;
        hb_t  hb_p;
        lscpwm_phase #(.REF_W(REF_W), .CW(CW)) u_ph (
            .clk      (clk),
            .rst_n    (rst_n),
            .ref_i    ($signed(ref_in[p*REF_W +: REF_W])),
            .load_i   (peak),
            .cnt_i    (cnt),
            .lvl_o    (lvl_p),
            .leg_hi_o (leg_hi[p]),
            .hb_o     (hb_p)
        );
        assign lvl_out[p*LVL_W +: LVL_W] = lvl_p;
        assign hb_out[p*HB_W +: HB_W]    = hb_p;
    end

    p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb |=> !samp_stb);

endmodule

// File: tb/tb_lscpwm_mod.sv
module tb_lscpwm_mod;
    localparam int NP    = 3;
    localparam int RW    = 8;
    localparam int CWB   = RW - 2;
    localparam int TOPV  = 1 << CWB;
    localparam int RTW   = $clog2(CWB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic car_tick = 1'b0;
    logic [RTW-1:0] car_rate = '0;
    logic [NP*RW-1:0] ref_in = '0;
    logic samp_stb;
    logic [NP-1:0] leg_hi;
    logic [NP*3-1:0] lvl_out;
    logic [NP*2-1:0] hb_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lscpwm_mod #(.NPHASE(NP), .REF_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .car_tick(car_tick), .car_rate(car_rate),
        .ref_in(ref_in), .samp_stb(samp_stb), .leg_hi(leg_hi),
        .lvl_out(lvl_out), .hb_out(hb_out)
    );

    typedef struct packed {
        logic [NP*3-1:0] lvl;
        logic [NP-1:0]   leg;
        logic [NP*2-1:0] hb;
        logic            stb;
        logic            rst;
    } exp_t;

    exp_t q[$];

    // Reference model state, built from the requirements.
    int m_cnt, m_up, m_sh;
    int m_ref [NP];

    // Driver side: predict outputs for this edge, then advance the model (R2, R7, R9).
    always @(posedge clk) begin
        exp_t e;
        e = '0;
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                e.lvl[p*3 +: 3] = 3'sd0;
                e.hb[p*2 +: 2]  = 2'sd1;
            end
            e.rst = 1'b1;
            q.push_back(e);
            m_cnt = 0; m_up = 1; m_sh = 0;
            for (int p = 0; p < NP; p++) m_ref[p] = 0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                int u, n, l, h;
                u = m_ref[p] + (1 << (RW - 1));
                n = 0;
                for (int k = 0; k < 4; k++) if (u > k * TOPV + m_cnt) n++;
                l = n - 2;
                h = (m_ref[p] > 0) ? l - 1 : l + 1;
                e.lvl[p*3 +: 3] = 3'(l);
                e.leg[p]        = (m_ref[p] > 0);
                e.hb[p*2 +: 2]  = 2'(h);
            end
            e.stb = car_tick && (m_cnt == TOPV);
            q.push_back(e);
            if (car_tick) begin
                if (m_cnt == TOPV) begin
                    for (int p = 0; p < NP; p++)
                        m_ref[p] = int'($signed(ref_in[p*RW +: RW]));
                    m_cnt = m_cnt - (1 << m_sh);
                    m_up = 0;
                end else if (m_cnt == 0) begin
                    m_sh = (int'(car_rate) > CWB) ? CWB : int'(car_rate); // R9 clamp
                    m_cnt = 1 << m_sh;
                    m_up = 1;
                end else if (m_up != 0) begin
                    m_cnt = m_cnt + (1 << m_sh);
                end else begin
                    m_cnt = m_cnt - (1 << m_sh);
                end
            end
        end
    end

    // Monitor: compare DUT outputs with the scoreboard between edges.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (samp_stb !== e.stb) begin
                errors++;
                $display("FAIL %s samp_stb got %b exp %b", e.rst ? "R1" : "R3", samp_stb, e.stb);
            end
            for (int p = 0; p < NP; p++) begin
                checks += 3;
                if (lvl_out[p*3 +: 3] !== e.lvl[p*3 +: 3]) begin
                    errors++;
                    $display("FAIL %s ph%0d lvl got %0d exp %0d",
                             e.rst ? "R1" : "R2 R4 R7 R8 R9", p,
                             $signed(lvl_out[p*3 +: 3]), $signed(e.lvl[p*3 +: 3]));
                end
                if (leg_hi[p] !== e.leg[p]) begin
                    errors++;
                    $display("FAIL %s ph%0d leg_hi got %b exp %b",
                             e.rst ? "R1" : "R5", p, leg_hi[p], e.leg[p]);
                end
                if (hb_out[p*2 +: 2] !== e.hb[p*2 +: 2] || $signed(hb_out[p*2 +: 2]) == -2) begin
                    errors++;
                    $display("FAIL %s ph%0d hb got %0d exp %0d",
                             e.rst ? "R1" : "R6", p,
                             $signed(hb_out[p*2 +: 2]), $signed(e.hb[p*2 +: 2]));
                end
            end
        end
    end

    task automatic set_refs(input int a, input int b, input int c);
        ref_in[0*RW +: RW] = RW'(a);
        ref_in[1*RW +: RW] = RW'(b);
        ref_in[2*RW +: RW] = RW'(c);
    endtask

    // Stimulus.
    initial begin
        int ph;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (5) @(negedge clk);           // R1 reset values
        rst_n = 1'b1;

        // Held mid-scale reference: mostly zero level.
        set_refs(0, 0, 0);
        car_tick = 1'b1;
        repeat (300) @(negedge clk);

        // Extremes and smallest positive value (R4, R5, R6 boundaries).
        set_refs(-128, 127, 1);
        repeat (300) @(negedge clk);
        set_refs(-1, 64, -64);
        repeat (300) @(negedge clk);

        // Fast-moving references with gapped ticks (R3: only the peak sample counts).
        ph = 0;
        for (int i = 0; i < 1500; i++) begin
            ph = (ph + 3) % 512;
            set_refs((ph < 256) ? ph - 128 : 383 - ph,
                     ((ph + 170) % 256) - 128,
                     128 - ((ph + 85) % 256) - 1);
            car_tick = ($urandom % 4) != 0;
            @(negedge clk);
        end

        // Rate changes at arbitrary times, including a clamped value (R9).
        for (int i = 0; i < 2500; i++) begin
            if (i % 37 == 0) car_rate = RTW'($urandom % 8);
            if (i % 5 == 0)
                set_refs(int'($urandom % 256) - 128, int'($urandom % 256) - 128,
                         int'($urandom % 256) - 128);
            car_tick = ($urandom % 3) != 0;
            @(negedge clk);
        end

        // Carrier stall: outputs must hold (R2).
        car_tick = 1'b0;
        repeat (50) @(negedge clk);

        // Reset in the middle of operation (R1).
        car_tick = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        car_rate = '0;
        set_refs(100, -100, 0);
        repeat (400) @(negedge clk);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got running exp finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule